// File: doc/BRIEF.md
# Segmented Dual-Slope Conversion Sequencer

This block is the digital controller of an integrating dual-slope converter. It closes the input switch so the integrator accumulates the input signal. It then opens that switch and closes the discharge switch, which returns the integrator to its starting level. Integration does not have a fixed length. It may stop only at the end of a 128-cycle slot, and only once the threshold comparator reports that the integrator has passed its threshold. A small input therefore integrates over many slots, and a large input over a single slot.

Discharge continues until the zero-crossing comparator reports that the integrator is back at its starting level. The number of discharge cycles, divided by the number of integration cycles, gives the measured quantity. The division happens outside this block.

Each conversion ends with a result beat on a valid/ready output stream. The beat carries both counts, a status code and a flag that marks the first result after reset. A one-cycle done pulse accompanies the beat. While a result waits for `res_ready`, back-pressure holds the sequencer with both switches open. The next conversion starts only after the beat has been accepted. Two overflow limits stop a conversion that would otherwise never end, and the conversion is then reported with a non-zero status.

Top module: `dual_slope_seq`

## Requirements
- R1: While reset is asserted, `in_sw_en`, `dis_sw_en`, `res_valid` and `done` are all low.
- R2: `in_sw_en` and `dis_sw_en` are never high in the same cycle. Exactly two cycles with both low come before every closing of the discharge switch, and at least two come before every closing of the input switch.
- R3: The integration phase (the cycles with `in_sw_en` high) lasts a whole number of 128-cycle slots, and never less than one slot. It ends at the first slot end at which `thr_cmp` is sampled high.
- R4: The discharge phase ends in the first cycle in which `zero_cmp` is sampled high, and that cycle is included. `res_dis_cnt` equals the number of cycles with `dis_sw_en` high.
- R5: When a conversion ends, `res_valid` rises together with a single-cycle `done` pulse. `res_int_cnt` then equals the number of cycles with `in_sw_en` high.
- R6: While `res_valid` is high and `res_ready` is low, the result fields stay stable and both switches stay open. A beat is transferred on a clock edge where `res_valid` and `res_ready` are both high. The next integration starts only after that transfer.
- R7: The integration limit is `OVF_LIMIT` cycles, which must be a multiple of 128. If integration reaches this limit without a threshold stop, the conversion ends with no discharge. The result then has status 1, `res_dis_cnt` equal to 0 and `res_int_cnt` equal to `OVF_LIMIT`.
- R8: If discharge reaches `DIS_LIMIT` cycles without a zero crossing, the discharge stops. The result then has status 2 and `res_dis_cnt` equal to `DIS_LIMIT`. A normal conversion has status 0.
- R9: `res_first` is 1 on the first result after each reset and 0 on every later result.
- R10: `thr_cmp` has no effect except at a slot end during integration. A threshold that is already high in the first cycle still gives a 128-cycle integration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_cmp | input | 1 | Threshold comparator, high once the integrator has passed its threshold |
| zero_cmp | input | 1 | Zero-crossing comparator, high once the integrator is back at its start level |
| in_sw_en | output | 1 | Input switch enable (integration) |
| dis_sw_en | output | 1 | Discharge switch enable |
| res_valid | output | 1 | Result beat valid |
| res_ready | input | 1 | Result beat accepted by the consumer |
| res_int_cnt | output | INT_W | Integration length in cycles |
| res_dis_cnt | output | DIS_W | Discharge length in cycles |
| res_status | output | 2 | 0 normal, 1 integration overflow, 2 discharge overflow |
| res_first | output | 1 | Marks the first result after reset, which should be discarded |
| done | output | 1 | One-cycle pulse as a result becomes valid |

## Verification
The following are checked by assertions on every cycle:
- the two switches are never closed together;
- the discharge switch closes only after two open cycles;
- integration always stops at a slot end;
- a held result stays stable under back-pressure;
- an integration overflow carries a zero discharge count;
- the discharge counter never passes its limit.

Only the directed scenarios can show the exact lengths that each comparator pattern produces. These include the rounding of a threshold up to the next slot end, the single-slot minimum with an early threshold, and the counts and status codes reported after each kind of overflow. They also include the first-result flag returning after a second reset.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  typedef enum logic [2:0] {
    PH_DEAD_IN  = 3'd0,
    PH_INTEG    = 3'd1,
    PH_DEAD_DIS = 3'd2,
    PH_DISCH    = 3'd3,
    PH_HOLD     = 3'd4
  } phase_e;

  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_INT_OVF = 2'd1,
    ST_DIS_OVF = 2'd2
  } status_e;
endpackage

// File: rtl/dsc_cycle_counter.sv
module dsc_cycle_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (en)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dsc_phase_fsm.sv
module dsc_phase_fsm
  import dsc_pkg::*;
#(
  parameter int INT_W     = 16,
  parameter int DIS_W     = 16,
  parameter int SLOT_LOG2 = 7,
  parameter int OVF_LIMIT = 65408,
  parameter int DIS_LIMIT = 65535,
  parameter int DEAD_CYC  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             thr_cmp,
  input  logic             zero_cmp,
  input  logic [INT_W-1:0] int_cnt,
  input  logic [DIS_W-1:0] dis_cnt,
  input  logic             res_accept,
  output logic             in_sw_en,
  output logic             dis_sw_en,
  output logic             int_clr,
  output logic             int_en,
  output logic             dis_clr,
  output logic             dis_en,
  output logic             cap_stb,
  output logic [INT_W-1:0] cap_int,
  output logic [DIS_W-1:0] cap_dis,
  output status_e          cap_status
);
  localparam int DZ_W = $clog2(DEAD_CYC + 1);
  localparam logic [DZ_W-1:0] DZ_LAST = DZ_W'(DEAD_CYC - 1);
  localparam logic [INT_W-1:0] INT_LAST = INT_W'(OVF_LIMIT - 1);
  localparam logic [DIS_W-1:0] DIS_LAST = DIS_W'(DIS_LIMIT - 1);

  phase_e           phase, nxt;
  logic [DZ_W-1:0]  dz_q;
  logic [INT_W-1:0] int_len_q, int_len_d;
  logic             slot_last;

  assign slot_last = &int_cnt[SLOT_LOG2-1:0];
  assign int_clr   = (phase == PH_DEAD_IN);
  assign int_en    = (phase == PH_INTEG);
  assign dis_clr   = (phase == PH_DEAD_DIS);
  assign dis_en    = (phase == PH_DISCH);

  always_comb begin
    nxt        = phase;
    int_len_d  = int_len_q;
    cap_stb    = 1'b0;
    cap_int    = int_len_q;
    cap_dis    = '0;
    cap_status = ST_OK;
    case (phase)
      PH_DEAD_IN:  if (dz_q == DZ_LAST) nxt = PH_INTEG;
      PH_INTEG: begin
        if (slot_last && thr_cmp) begin
          nxt       = PH_DEAD_DIS;
          int_len_d = INT_W'(int_cnt + 1'b1);
        end else if (int_cnt == INT_LAST) begin
          nxt        = PH_HOLD;
          cap_stb    = 1'b1;
          cap_int    = INT_W'(OVF_LIMIT);
          cap_status = ST_INT_OVF;
        end
      end
      PH_DEAD_DIS: if (dz_q == DZ_LAST) nxt = PH_DISCH;
      PH_DISCH: begin
        if (zero_cmp) begin
          nxt     = PH_HOLD;
          cap_stb = 1'b1;
          cap_dis = DIS_W'(dis_cnt + 1'b1);
        end else if (dis_cnt == DIS_LAST) begin
          nxt        = PH_HOLD;
          cap_stb    = 1'b1;
          cap_dis    = DIS_W'(DIS_LIMIT);
          cap_status = ST_DIS_OVF;
        end
      end
      PH_HOLD:     if (res_accept) nxt = PH_DEAD_IN;
      default:     nxt = PH_DEAD_IN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_DEAD_IN;
      dz_q      <= '0;
      int_len_q <= '0;
      in_sw_en  <= 1'b0;
      dis_sw_en <= 1'b0;
    end else begin
      phase     <= nxt;
      int_len_q <= int_len_d;
      in_sw_en  <= (nxt == PH_INTEG);
      dis_sw_en <= (nxt == PH_DISCH);
      if (nxt != phase) dz_q <= '0;
      else if (phase == PH_DEAD_IN || phase == PH_DEAD_DIS) dz_q <= dz_q + 1'b1;
    end
  end

  // R8: the discharge counter never runs past its limit
  assert_dis_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dis_en |-> (dis_cnt < DIS_W'(DIS_LIMIT)));

  // R2: the input switch and the discharge counter are never active together
  assert_int_dis_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_sw_en |-> !dis_en);
endmodule

// File: rtl/dsc_result_stage.sv
module dsc_result_stage
  import dsc_pkg::*;
#(
  parameter int INT_W     = 16,
  parameter int DIS_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_stb,
  input  logic [INT_W-1:0] cap_int,
  input  logic [DIS_W-1:0] cap_dis,
  input  status_e          cap_status,
  input  logic             res_ready,
  output logic             res_valid,
  output logic [INT_W-1:0] res_int_cnt,
  output logic [DIS_W-1:0] res_dis_cnt,
  output logic [1:0]       res_status,
  output logic             res_first,
  output logic             done
);
  logic first_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_int_cnt <= '0;
      res_dis_cnt <= '0;
      res_status  <= ST_OK;
      res_first   <= 1'b0;
      done        <= 1'b0;
      first_pend  <= 1'b1;
    end else begin
      done <= cap_stb;
      if (cap_stb) begin
        res_valid   <= 1'b1;
        res_int_cnt <= cap_int;
        res_dis_cnt <= cap_dis;
        res_status  <= cap_status;
        res_first   <= first_pend;
      end else if (res_valid && res_ready) begin
        res_valid  <= 1'b0;
        first_pend <= 1'b0;
      end
    end
  end

  // R6: a stalled beat keeps its content
  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_int_cnt) &&
                                   $stable(res_dis_cnt) && $stable(res_status)));

  // R5: done only marks a beat that is valid
  assert_done_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> res_valid);

  // R7: an integration overflow reports a zero discharge count
  assert_int_ovf_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_status == ST_INT_OVF) |-> (res_dis_cnt == '0));
endmodule

// File: rtl/dual_slope_seq.sv
module dual_slope_seq
  import dsc_pkg::*;
#(
  parameter int INT_W     = 16,
  parameter int DIS_W     = 16,
  parameter int SLOT_LOG2 = 7,
  parameter int OVF_LIMIT = (1 << INT_W) - (1 << SLOT_LOG2),
  parameter int DIS_LIMIT = (1 << DIS_W) - 1,
  parameter int DEAD_CYC  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             thr_cmp,
  input  logic             zero_cmp,
  output logic             in_sw_en,
  output logic             dis_sw_en,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [INT_W-1:0] res_int_cnt,
  output logic [DIS_W-1:0] res_dis_cnt,
  output logic [1:0]       res_status,
  output logic             res_first,
  output logic             done
);
  logic [INT_W-1:0] int_cnt, cap_int;
  logic [DIS_W-1:0] dis_cnt, cap_dis;
  logic             int_clr, int_en, dis_clr, dis_en, cap_stb;
  status_e          cap_status;

  dsc_cycle_counter #(.W(INT_W)) u_int_cnt (
    .clk(clk), .rst_n(rst_n), .clr(int_clr), .en(int_en), .cnt(int_cnt));

  dsc_cycle_counter #(.W(DIS_W)) u_dis_cnt (
    .clk(clk), .rst_n(rst_n), .clr(dis_clr), .en(dis_en), .cnt(dis_cnt));

  dsc_phase_fsm #(
    .INT_W(INT_W), .DIS_W(DIS_W), .SLOT_LOG2(SLOT_LOG2),
    .OVF_LIMIT(OVF_LIMIT), .DIS_LIMIT(DIS_LIMIT), .DEAD_CYC(DEAD_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .thr_cmp(thr_cmp), .zero_cmp(zero_cmp),
    .int_cnt(int_cnt), .dis_cnt(dis_cnt), .res_accept(res_valid && res_ready),
    .in_sw_en(in_sw_en), .dis_sw_en(dis_sw_en),
    .int_clr(int_clr), .int_en(int_en), .dis_clr(dis_clr), .dis_en(dis_en),
    .cap_stb(cap_stb), .cap_int(cap_int), .cap_dis(cap_dis), .cap_status(cap_status));

  dsc_result_stage #(.INT_W(INT_W), .DIS_W(DIS_W)) u_res (
    .clk(clk), .rst_n(rst_n), .cap_stb(cap_stb), .cap_int(cap_int),
    .cap_dis(cap_dis), .cap_status(cap_status), .res_ready(res_ready),
    .res_valid(res_valid), .res_int_cnt(res_int_cnt), .res_dis_cnt(res_dis_cnt),
    .res_status(res_status), .res_first(res_first), .done(done));

  // R2: the two switches are mutually exclusive
  assert_sw_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_sw_en && dis_sw_en));

  // R2: two open cycles precede the discharge switch
  assert_dead_dis_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dis_sw_en) |-> (!$past(in_sw_en) && !$past(in_sw_en, 2)));

  // R3: integration only stops at the last cycle of a slot
  assert_slot_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_sw_en) |-> $past(&int_cnt[SLOT_LOG2-1:0]));
endmodule

// File: tb/dual_slope_seq_tb.sv
module dual_slope_seq_tb;
  localparam int INT_W = 16;
  localparam int DIS_W = 16;
  localparam int OVF_LIM = 1024;
  localparam int DIS_LIM = 512;

  logic clk = 1'b0;
  logic rst_n, thr_cmp, zero_cmp, res_ready;
  logic in_sw_en, dis_sw_en, res_valid, res_first, done;
  logic [INT_W-1:0] res_int_cnt;
  logic [DIS_W-1:0] res_dis_cnt;
  logic [1:0] res_status;

  int checks = 0, errors = 0;
  int mon_checks = 0, mon_errors = 0;
  int tgt_n = 1, tgt_m = 1;
  int in_run = 0, dis_run = 0, gap = 100, done_cnt = 0;
  logic prev_in = 1'b0, prev_dis = 1'b0;

  always #2 clk = ~clk;

  dual_slope_seq #(.INT_W(INT_W), .DIS_W(DIS_W), .SLOT_LOG2(7),
                   .OVF_LIMIT(OVF_LIM), .DIS_LIMIT(DIS_LIM), .DEAD_CYC(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .thr_cmp(thr_cmp), .zero_cmp(zero_cmp),
    .in_sw_en(in_sw_en), .dis_sw_en(dis_sw_en), .res_valid(res_valid),
    .res_ready(res_ready), .res_int_cnt(res_int_cnt), .res_dis_cnt(res_dis_cnt),
    .res_status(res_status), .res_first(res_first), .done(done));

  // Comparator model and switch monitor
  initial begin thr_cmp = 1'b0; zero_cmp = 1'b0; end
  always @(negedge clk) begin
    if (!rst_n) begin
      in_run = 0; dis_run = 0; gap = 100; prev_in = 1'b0; prev_dis = 1'b0;
      thr_cmp = 1'b0; zero_cmp = 1'b0;
    end else begin
      if (in_sw_en && dis_sw_en) begin
        mon_errors++; $display("FAIL R2 both switches closed act=11 exp=not both");
      end
      if (in_sw_en && !prev_in) begin
        mon_checks++;
        if (gap < 2) begin mon_errors++; $display("FAIL R2 gap before input act=%0d exp>=2", gap); end
        in_run = 0; dis_run = 0;
      end
      if (dis_sw_en && !prev_dis) begin
        mon_checks++;
        if (gap != 2) begin mon_errors++; $display("FAIL R2 gap before discharge act=%0d exp=2", gap); end
      end
      if (!in_sw_en && !dis_sw_en) gap++; else gap = 0;
      if (in_sw_en) in_run++;
      if (dis_sw_en) dis_run++;
      thr_cmp  = (in_run >= tgt_n);
      zero_cmp = (dis_run >= tgt_m);
      if (done) done_cnt++;
      prev_in = in_sw_en; prev_dis = dis_sw_en;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s act=%0d exp=%0d", tag, act, exp); end
  endtask

  task automatic run_conv(input int n, input int m, input int exp_int, input int exp_dis,
                          input int exp_st, input int exp_first, input bit stall);
    int d0, waitc;
    tgt_n = n; tgt_m = m;
    d0 = done_cnt;
    waitc = 0;
    while (!res_valid && waitc < 20000) begin @(negedge clk); waitc++; end
    check(res_valid, "R5 result never valid", res_valid, 1);
    check(done == 1'b1, "R5 done with first valid cycle", done, 1);
    if (stall) begin
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        check(res_valid && !in_sw_en && !dis_sw_en, "R6 hold with switches open",
              {res_valid, in_sw_en, dis_sw_en}, 3'b100);
        check(res_int_cnt == exp_int && res_dis_cnt == exp_dis, "R6 stable int count",
              res_int_cnt, exp_int);
        check(done == 1'b0, "R5 done single cycle", done, 0);
      end
    end
    check(res_int_cnt == exp_int, "R3 integration count", res_int_cnt, exp_int);
    check(in_run == exp_int, "R5 input switch cycles", in_run, exp_int);
    check(res_dis_cnt == exp_dis, "R4 discharge count", res_dis_cnt, exp_dis);
    check(dis_run == exp_dis, "R4 discharge switch cycles", dis_run, exp_dis);
    check(res_status == exp_st, "R7 R8 status", res_status, exp_st);
    check(res_first == exp_first, "R9 first flag", res_first, exp_first);
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    @(negedge clk);
    check(!res_valid, "R6 beat accepted", res_valid, 0);
    check(done_cnt == d0 + 1, "R5 one done per conversion", done_cnt - d0, 1);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; res_ready = 1'b0;
    repeat (3) @(negedge clk);
    check(!in_sw_en && !dis_sw_en && !res_valid && !done, "R1 reset outputs",
          {in_sw_en, dis_sw_en, res_valid, done}, 0);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("CHECKS %0d ERRORS %0d", checks + mon_checks, errors + mon_errors);
    $finish;
  end

  initial begin
    do_reset();
    run_conv(1, 5, 128, 5, 0, 1, 1'b0);        // R10 R3 minimum slot, R9 first
    run_conv(200, 40, 256, 40, 0, 0, 1'b0);    // R3 rounds up to slot end
    run_conv(384, 1, 384, 1, 0, 0, 1'b0);      // R3 exact boundary, R4 single cycle
    run_conv(129, 300, 256, 300, 0, 0, 1'b1);  // R6 back-pressure
    run_conv(1000000, 5, OVF_LIM, 0, 1, 0, 1'b0); // R7 integration overflow
    run_conv(10, 1000000, 128, DIS_LIM, 2, 0, 1'b0); // R8 discharge overflow
    run_conv(600, 7, 640, 7, 0, 0, 1'b0);      // R7 recovery
    do_reset();
    run_conv(50, 3, 128, 3, 0, 1, 1'b0);       // R9 first flag after second reset
    $display("CHECKS %0d ERRORS %0d", checks + mon_checks, errors + mon_errors);
    $finish;
  end
endmodule